// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block holds a set of counters that software uses to measure activity in the surrounding logic. One dedicated counter tracks clock cycles. Four further counters can each be pointed at one line of an incoming event vector. Each of these counts the cycles in which its chosen line is high. All five counters are 32 bits wide and run only while a global enable and their own per-counter enable are both on. A divider bit slows the cycle counter to one step per 64 clocks.

Software reaches the block through a simple synchronous register port. A write takes effect on the clock edge where the write strobe is sampled, and read data follows the address combinationally. The per-counter enables and the interrupt enables each have a pair of registers: writing a one to the first sets a bit, and writing a one to the second clears it. The four event counters share one window: a select register picks the counter that the type and count registers reach. Software can preload a counter with the two's complement of a period N. The counter then wraps after N steps, latches a sticky overflow flag, and raises the interrupt line if that counter's interrupt is enabled.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every register reads zero (control, enables, interrupt enables, flags, select, types, all counts) and `irq_o` is low.
- R2: Event counter n adds one on each clock edge where the control enable bit (control bit 0) is set, enable bit n is set, and `events_i[type_n]` is high. Event type k means bit k of `events_i`, and a type at or above the vector width never counts.
- R3: With control bit 3 clear, the cycle counter adds one on every clock edge where control bit 0 and enable bit 31 are both set.
- R4: With control bit 3 set, the cycle counter adds one only on every 64th edge in which it is enabled, counting from its last clear.
- R5: Enable set (address 0x1) and enable clear (address 0x2) act per bit: a one sets or clears that counter's enable, and a zero leaves it unchanged. Bits 0 to 3 belong to event counters 0 to 3 and bit 31 to the cycle counter. Both addresses read back the current enable mask.
- R6: Interrupt-enable set (0x3) and clear (0x4) behave like R5 with the same bit mapping, and both read back the interrupt-enable mask.
- R7: A counter stepping from 0xFFFFFFFF to 0 sets its flag at address 0x5 on that same edge, using the R5 bit mapping. Writing ones to 0x5 clears those flags. A wrap in the same cycle as a clear leaves the flag set.
- R8: `irq_o` is high exactly while some flag and its interrupt enable are both set.
- R9: Writing control (address 0x0) with bit 1 set zeroes all event counters, and with bit 2 set zeroes the cycle counter and its divider, on that edge. Both bits always read as zero. Bits 0 and 3 are stored and read back.
- R10: The select register (0x6, bits 1:0) picks one event counter. The type register (0x7, bits 7:0) and the count register (0x8) read and write only the selected counter.
- R11: The cycle counter is read and written directly at 0x9. A software write to any counter wins over an increment in the same cycle.
- R12: Addresses 0xA to 0xF read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| events_i | input | EVT_LINES | Event lines, one per event type |
| irq_o | output | 1 | Level interrupt, high while an enabled flag is pending |

## Verification
Register writes, counter steps and flag updates all land on the edge that samples them. Read data and `irq_o` then follow on the same cycle with no further delay. So every expected value applies one edge after the stimulus, and the monitor samples it shortly before the next rising edge. Count windows are bounded by the two writes that turn the global enable on and off, or by a fixed number of event-high edges. This makes each expected count equal to the number of enabled edges in that window. For the divided cycle counter this is 3 steps across 200 enabled edges.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int PMU_DW   = 32;
  localparam int PMU_NEVT = 4;
  localparam int PMU_NCNT = PMU_NEVT + 1;
  localparam int PMU_AW   = 4;
  localparam int PMU_TW   = 8;

  localparam int CTL_RUN  = 0;
  localparam int CTL_EZRO = 1;
  localparam int CTL_CZRO = 2;
  localparam int CTL_DIV  = 3;
  localparam int CYC_POS  = 31;

  typedef enum logic [PMU_AW-1:0] {
    A_CTRL   = 4'h0,
    A_EN_SET = 4'h1,
    A_EN_CLR = 4'h2,
    A_IE_SET = 4'h3,
    A_IE_CLR = 4'h4,
    A_FLAGS  = 4'h5,
    A_SEL    = 4'h6,
    A_ETYPE  = 4'h7,
    A_ECNT   = 4'h8,
    A_CCNT   = 4'h9
  } pmu_addr_e;

  // Register bit image -> internal mask (event counters low, cycle counter top)
  function automatic logic [PMU_NCNT-1:0] pmu_unpack(input logic [PMU_DW-1:0] w);
    return {w[CYC_POS], w[PMU_NEVT-1:0]};
  endfunction

  // Internal mask -> register bit image
  function automatic logic [PMU_DW-1:0] pmu_pack(input logic [PMU_NCNT-1:0] m);
    logic [PMU_DW-1:0] w;
    w = '0;
    w[PMU_NEVT-1:0] = m[PMU_NEVT-1:0];
    w[CYC_POS] = m[PMU_NEVT];
    return w;
  endfunction

  // Next count and carry-out of one increment
  function automatic logic [PMU_DW:0] pmu_step(input logic [PMU_DW-1:0] v);
    return {1'b0, v} + {{PMU_DW{1'b0}}, 1'b1};
  endfunction

  // Per-bit set/clear update of an enable mask
  function automatic logic [PMU_NCNT-1:0] pmu_setclr(input logic [PMU_NCNT-1:0] cur,
                                                     input logic [PMU_NCNT-1:0] s,
                                                     input logic [PMU_NCNT-1:0] c);
    return (cur | s) & ~c;
  endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld,
  input  logic [PMU_DW-1:0] ld_val,
  input  logic              inc,
  output logic [PMU_DW-1:0] cnt,
  output logic              wrap
);

  logic [PMU_DW:0] nxt;
  assign nxt  = pmu_step(cnt);
  assign wrap = inc & ~clr & ~ld & nxt[PMU_DW];

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (inc)  cnt <= nxt[PMU_DW-1:0];
  end

  // R2 / R3: an unobstructed increment moves the count by exactly one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !ld) |=> (cnt == $past(cnt) + 32'd1));

  // R11: a software load wins over an increment
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (cnt == $past(ld_val)));

  // R9: a zeroing request empties the counter
  assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic div,
  output logic tick
);

  logic [DIV_LOG2-1:0] phase;

  assign tick = run & (~div | (&phase));

  always_ff @(posedge clk) begin
    if (!rst_n)          phase <= '0;
    else if (clr)        phase <= '0;
    else if (run && div) phase <= phase + 1'b1;
  end

  // R4: a divided tick is never followed by another divided tick
  assert_div_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div && !clr) |=> !(tick && div));

endmodule

// File: rtl/pmu_evt_match.sv
module pmu_evt_match
  import pmu_pkg::*;
#(
  parameter int EVT_LINES = 32
) (
  input  logic [EVT_LINES-1:0] ev,
  input  logic [PMU_TW-1:0]    etype,
  output logic                 hit
);

  localparam int SPAN = 1 << PMU_TW;

  logic [SPAN-1:0] ev_ext;
  assign ev_ext = SPAN'(ev);
  assign hit    = ev_ext[etype];

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int EVT_LINES = 32,
  parameter int DIV_LOG2  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [PMU_AW-1:0]    reg_addr,
  input  logic [PMU_DW-1:0]    reg_wdata,
  output logic [PMU_DW-1:0]    reg_rdata,
  input  logic [EVT_LINES-1:0] events_i,
  output logic                 irq_o
);

  localparam int SEL_W = (PMU_NEVT > 1) ? $clog2(PMU_NEVT) : 1;
  localparam int CYC   = PMU_NEVT;

  // Stored state
  logic                 run_q, div_q;
  logic [PMU_NCNT-1:0]  en_q, ie_q, flag_q;
  logic [SEL_W-1:0]     sel_q;
  logic [PMU_TW-1:0]    etype_q [PMU_NEVT];

  // Named internal events
  logic                 wr_ctrl, wr_en_s, wr_en_c, wr_ie_s, wr_ie_c;
  logic                 wr_flag, wr_sel, wr_etype, wr_ecnt, wr_ccnt;
  logic                 ezero_pulse, czero_pulse;
  logic [PMU_NCNT-1:0]  wmask;
  logic [PMU_NCNT-1:0]  wrap_vec;
  logic [PMU_NCNT-1:0]  inc_vec;
  logic [PMU_NEVT-1:0]  hit_vec;
  logic [PMU_DW-1:0]    ecnt [PMU_NEVT];
  logic [PMU_DW-1:0]    ccnt;
  logic                 cyc_tick;

  assign wmask    = pmu_unpack(reg_wdata);
  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign wr_en_s  = reg_we && (reg_addr == A_EN_SET);
  assign wr_en_c  = reg_we && (reg_addr == A_EN_CLR);
  assign wr_ie_s  = reg_we && (reg_addr == A_IE_SET);
  assign wr_ie_c  = reg_we && (reg_addr == A_IE_CLR);
  assign wr_flag  = reg_we && (reg_addr == A_FLAGS);
  assign wr_sel   = reg_we && (reg_addr == A_SEL);
  assign wr_etype = reg_we && (reg_addr == A_ETYPE);
  assign wr_ecnt  = reg_we && (reg_addr == A_ECNT);
  assign wr_ccnt  = reg_we && (reg_addr == A_CCNT);

  assign ezero_pulse = wr_ctrl & reg_wdata[CTL_EZRO];
  assign czero_pulse = wr_ctrl & reg_wdata[CTL_CZRO];

  // Control, enables, select, types
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      div_q <= 1'b0;
      en_q  <= '0;
      ie_q  <= '0;
      sel_q <= '0;
      for (int i = 0; i < PMU_NEVT; i++) etype_q[i] <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= reg_wdata[CTL_RUN];
        div_q <= reg_wdata[CTL_DIV];
      end
      en_q <= pmu_setclr(en_q, wr_en_s ? wmask : '0, wr_en_c ? wmask : '0);
      ie_q <= pmu_setclr(ie_q, wr_ie_s ? wmask : '0, wr_ie_c ? wmask : '0);
      if (wr_sel)   sel_q <= reg_wdata[SEL_W-1:0];
      if (wr_etype) etype_q[sel_q] <= reg_wdata[PMU_TW-1:0];
    end
  end

  // Sticky overflow flags: a wrap beats a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~(wr_flag ? wmask : '0)) | wrap_vec;
  end

  // Event counters
  for (genvar g = 0; g < PMU_NEVT; g++) begin : g_evt
    pmu_evt_match #(.EVT_LINES(EVT_LINES)) u_match (
      .ev    (events_i),
      .etype (etype_q[g]),
      .hit   (hit_vec[g])
    );

    assign inc_vec[g] = run_q & en_q[g] & hit_vec[g];

    pmu_counter u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ezero_pulse),
      .ld     (wr_ecnt && (sel_q == SEL_W'(g))),
      .ld_val (reg_wdata),
      .inc    (inc_vec[g]),
      .cnt    (ecnt[g]),
      .wrap   (wrap_vec[g])
    );
  end

  // Cycle counter with optional divider
  pmu_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (czero_pulse),
    .run   (run_q & en_q[CYC]),
    .div   (div_q),
    .tick  (cyc_tick)
  );

  assign inc_vec[CYC] = cyc_tick;

  pmu_counter u_ccnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (czero_pulse),
    .ld     (wr_ccnt),
    .ld_val (reg_wdata),
    .inc    (cyc_tick),
    .cnt    (ccnt),
    .wrap   (wrap_vec[CYC])
  );

  // Read path
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTL_RUN] = run_q;
        reg_rdata[CTL_DIV] = div_q;
      end
      A_EN_SET, A_EN_CLR: reg_rdata = pmu_pack(en_q);
      A_IE_SET, A_IE_CLR: reg_rdata = pmu_pack(ie_q);
      A_FLAGS:            reg_rdata = pmu_pack(flag_q);
      A_SEL:              reg_rdata[SEL_W-1:0] = sel_q;
      A_ETYPE:            reg_rdata[PMU_TW-1:0] = etype_q[sel_q];
      A_ECNT:             reg_rdata = ecnt[sel_q];
      A_CCNT:             reg_rdata = ccnt;
      default:            reg_rdata = '0;
    endcase
  end

  assign irq_o = |(flag_q & ie_q);

  // Per-counter properties
  for (genvar k = 0; k < PMU_NCNT; k++) begin : g_chk
    // R7: a wrap raises the flag on the same edge
    assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_vec[k] |=> flag_q[k]);

    // R5: a clear write drops the enable
    assert_en_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_c && wmask[k]) |=> !en_q[k]);

    // R8: an enabled wrap drives the interrupt on the following cycle
    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_vec[k] && ie_q[k] && !(wr_ie_c && wmask[k])) |=> irq_o);

    // R2 / R3: nothing counts while the global enable is off
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !inc_vec[k]);
  end

  // R9: control zeroing bits never read back
  assert_ctrl_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ((reg_addr != A_CTRL) || (reg_rdata[CTL_CZRO:CTL_EZRO] == 2'b00)));

endmodule

// File: tb/sim_perf_mon_unit.sv
`timescale 1ns/1ps
module sim_perf_mon_unit;

  localparam int LINES = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [3:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [LINES-1:0]  events_i = '0;
  logic              irq_o;

  always #10 clk = ~clk;  // 50 MHz

  perf_mon_unit #(.EVT_LINES(LINES), .DIV_LOG2(6)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events_i(events_i),
    .irq_o(irq_o)
  );

  // Own register addresses
  localparam logic [3:0] CTL = 4'h0, ENS = 4'h1, ENC = 4'h2, IES = 4'h3,
                         IEC = 4'h4, FLG = 4'h5, SEL = 4'h6, TYP = 4'h7,
                         ECN = 4'h8, CCN = 4'h9, BAD = 4'hF;

  typedef struct {
    string       tag;
    bit          is_irq;
    logic [3:0]  addr;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Monitor: pops expectations and compares shortly before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr=%0h actual=%08h expected=%08h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.tag = tag; it.is_irq = 0; it.addr = a; it.exp = e;
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic irq_chk(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.tag = tag; it.is_irq = 1; it.addr = 4'h0; it.exp = {31'b0, e};
    q.push_back(it);
    @(posedge clk);
  endtask

  task automatic pulse(input logic [LINES-1:0] m, input int n);
    @(negedge clk);
    events_i = m;
    repeat (n) @(negedge clk);
    events_i = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_chk(CTL, 32'h0, "R1 ctrl");
    rd_chk(ENS, 32'h0, "R1 enables");
    rd_chk(FLG, 32'h0, "R1 flags");
    rd_chk(CCN, 32'h0, "R1 cycle count");
    irq_chk(1'b0, "R1 irq");

    // R10: per-counter types through the select window
    wr(SEL, 2); wr(TYP, 7);
    wr(SEL, 1); wr(TYP, 3);
    wr(SEL, 0); wr(TYP, 5);
    wr(ENS, 32'h4);
    wr(CTL, 32'h1);
    pulse((32'h1 << 7) | (32'h1 << 3), 5);
    wr(SEL, 2);
    rd_chk(ECN, 32'd5, "R2 counter2 five events");
    wr(SEL, 1);
    rd_chk(ECN, 32'd0, "R5 disabled counter1 holds");
    rd_chk(TYP, 32'd3, "R10 type of selected counter1");
    rd_chk(ENS, 32'h4, "R5 enable mask");

    // R5: zero bits ignored, set and clear per bit
    wr(ENS, 32'h0);
    rd_chk(ENC, 32'h4, "R5 zero write ignored");
    wr(ENS, 32'h2); wr(ENC, 32'h4);
    rd_chk(ENS, 32'h2, "R5 set/clear");
    pulse((32'h1 << 7) | (32'h1 << 3), 4);
    rd_chk(ECN, 32'd4, "R2 counter1 four events");
    wr(SEL, 2);
    rd_chk(ECN, 32'd5, "R5 cleared counter2 holds");

    // R3: undivided cycle counting over 20 enabled edges
    wr(CTL, 32'h0);
    wr(ENS, 32'h8000_0000);
    wr(CTL, 32'h1);
    repeat (18) @(negedge clk);
    wr(CTL, 32'h0);
    rd_chk(CCN, 32'd20, "R3 cycle count");

    // R11: load wins over a same-cycle increment
    wr(CTL, 32'h1); wr(CCN, 32'd100); wr(CTL, 32'h0);
    rd_chk(CCN, 32'd102, "R11 load then two steps");

    // R9: cycle zeroing, self-clearing bit
    wr(CTL, 32'h4);
    rd_chk(CCN, 32'd0, "R9 cycle counter zeroed");
    rd_chk(CTL, 32'h0, "R9 zero bit reads back 0");

    // R4: divided counting over 200 enabled edges gives 3
    wr(CTL, 32'h8);
    wr(CTL, 32'h9);
    repeat (198) @(negedge clk);
    wr(CTL, 32'h8);
    rd_chk(CCN, 32'd3, "R4 divided cycle count");
    rd_chk(CTL, 32'h8, "R4 divider bit stored");
    wr(CTL, 32'h0); wr(CTL, 32'h4);

    // R7 / R8 / R6: overflow, interrupt
    wr(SEL, 0); wr(ECN, 32'hFFFF_FFFE);
    wr(ENS, 32'h1); wr(IES, 32'h1); wr(CTL, 32'h1);
    pulse(32'h1 << 5, 1);
    rd_chk(ECN, 32'hFFFF_FFFF, "R2 counter0 one step");
    irq_chk(1'b0, "R8 no irq before wrap");
    pulse(32'h1 << 5, 1);
    rd_chk(ECN, 32'h0, "R7 wrapped to zero");
    rd_chk(FLG, 32'h1, "R7 flag set on wrap");
    irq_chk(1'b1, "R8 irq high");
    rd_chk(IEC, 32'h1, "R6 ie mask");
    wr(IEC, 32'h1);
    irq_chk(1'b0, "R6 ie cleared drops irq");
    rd_chk(FLG, 32'h1, "R7 flag stays pending");
    wr(IES, 32'h1);
    irq_chk(1'b1, "R6 ie set raises irq");
    wr(FLG, 32'h1);
    rd_chk(FLG, 32'h0, "R7 flag cleared by write");
    irq_chk(1'b0, "R8 irq drops after clear");

    // R9: event zeroing
    wr(CTL, 32'h3);
    rd_chk(CTL, 32'h1, "R9 event zero bit reads 0");
    wr(SEL, 1);
    rd_chk(ECN, 32'h0, "R9 counter1 zeroed");
    wr(SEL, 2);
    rd_chk(ECN, 32'h0, "R9 counter2 zeroed");
    rd_chk(TYP, 32'd7, "R10 type of counter2");

    // R12: unmapped address
    wr(BAD, 32'hFFFF_FFFF);
    rd_chk(BAD, 32'h0, "R12 unmapped reads zero");
    rd_chk(CTL, 32'h1, "R12 ctrl unchanged");
    rd_chk(ENS, 32'h8000_0003, "R12 enables unchanged");

    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end

endmodule